// File: doc/BRIEF.md
# Chained Three-Channel Interval Timer

This block holds three identical up-counting timer channels behind one register bus. Each channel can count on the master clock, on rising edges of a shared slow clock input, or on rising edges of a routed clock input. A block routing register chooses which neighbouring channel's waveform output drives each channel's routed clock input. A block control register can restart all three counters in the same clock edge.

Each channel drives a waveform output that is set when the counter reaches compare value A and cleared when it reaches compare value C. The usual setup puts channel 0 in free-run with A at 0 and C at half range. Its waveform output then rises once per full wrap. Routing that output into channel 1 makes channel 1 count the wraps. A concatenated view returns the low half and latches the high half, so software can read a consistent 32-bit value. Channel 2 stays free as a periodic or one-shot event timer. When the counter width parameter is set to 32, channel 0 alone gives the free-running count.

Register map: channel n sits at n*0x40. Its offsets are 0x00 command (write), 0x04 mode, 0x08 compare A, 0x0C compare C and 0x10 counter value (read). The block registers are 0xC0 command, 0xC4 routing, 0xC8 view low and 0xCC view high. Reads are combinational. Writes take effect at the clock edge that samples them.

Top module: `tmr_block3`

## Requirements
- R1: After reset every counter reads 0, the routing register reads 0, and all waveform and event outputs are low.
- R2: A channel command write with bit 0 set starts counting and with bit 1 set stops it; bit 1 wins when both are set. Bit 2 zeroes the counter at that edge. With mode clock source 0 (mode bits [1:0]), a running channel adds one per master clock cycle, and a stopped channel holds its value.
- R3: Without auto-reload (mode bit 2 clear), the counter wraps from 2^W-1 to 0, where W is the counter width parameter. With W=32 it counts past 0xFFFF.
- R4: The waveform output goes high at the edge where the counter takes the value of compare A. It goes low at the edge where the counter takes the value of compare C, and the clear wins when both match.
- R5: With auto-reload (mode bit 2), the counter runs 0..C and then returns to 0, a period of C+1 ticks. The event output is high for exactly the one cycle after the counter takes the value C.
- R6: With stop-on-compare (mode bit 3), the counter halts at C and pulses the event output once. It holds C until a command with bits 0 and 2 restarts it from 0.
- R7: The routing register holds 6 bits, two per channel at bits [2n+1:2n]. The code 1 selects the waveform of channel (n+2) mod 3 and the code 2 selects channel (n+1) mod 3. Codes 0 and 3 select a constant low. The register reads back the written value masked to 6 bits.
- R8: With clock source 2, a channel adds one per rising edge of its routed input. The count lands at the edge after the source waveform rises, and there is at most one count per master cycle.
- R9: Consider channel 0 free-running with A=0 and C=0x8000, and channel 1 on routed input code 1. Channel 1 then adds one each time channel 0 wraps, one cycle after the wrap.
- R10: Writing the block command with bit 0 set zeroes all three counters at the same edge.
- R11: With clock source 1, a channel adds one per rising edge of the slow clock input. A level held high adds no further counts.
- R12: Reading view low returns channel 0's counter. At that edge it copies channel 1's counter into a holding register, which view high returns until the next view-low read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used by the view-low latch) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| slow_clk | input | 1 | Slow clock input, edge-detected in the master domain |
| wave_out | output | 3 | Per-channel waveform outputs |
| cmp_evt | output | 3 | Per-channel one-cycle compare-C event pulses |

## Verification
A channel whose run flag or counter is wrong shows up on the counter read, as early as the cycle after the stimulus. A wrong waveform bit shows up on channel 1's count one cycle after a wrap. Routing faults show up as a frozen upper half in the 32-bit read, and holding-register faults as a high half that disagrees with the counter just latched. The bench samples the waveform and event outputs and the counter values cycle by cycle across one reload period, one one-shot stop and the wrap of the low channel. Off-by-one faults in compare timing therefore show up within a single cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH   = 3;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int OFSW  = 6;
    localparam int SELW  = AW - OFSW;
    localparam int RTW   = 2 * NCH;

    localparam logic [OFSW-1:0] OFS_CMD  = 6'h00;
    localparam logic [OFSW-1:0] OFS_MODE = 6'h04;
    localparam logic [OFSW-1:0] OFS_CMPA = 6'h08;
    localparam logic [OFSW-1:0] OFS_CMPC = 6'h0C;
    localparam logic [OFSW-1:0] OFS_CNT  = 6'h10;

    localparam logic [AW-1:0] BLK_CMD   = 8'hC0;
    localparam logic [AW-1:0] BLK_ROUTE = 8'hC4;
    localparam logic [AW-1:0] VIEW_LO   = 8'hC8;
    localparam logic [AW-1:0] VIEW_HI   = 8'hCC;

    typedef enum logic [1:0] {
        SRC_MCK  = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_RTE  = 2'd2,
        SRC_OFF  = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_PREV = 2'd1,
        RT_NEXT = 2'd2,
        RT_OFF  = 2'd3
    } route_e;

    typedef struct packed {
        logic     stop_on_c;
        logic     auto_rld;
        clk_src_e src;
    } ch_mode_t;

    function automatic int prev_ch(input int n);
        return (n + NCH - 1) % NCH;
    endfunction

    function automatic int next_ch(input int n);
        return (n + 1) % NCH;
    endfunction
endpackage

// File: rtl/tmr_rise.sv
module tmr_rise (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= din;
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          trig,
    input  logic          cmd_we,
    input  logic          mode_we,
    input  logic          cmpa_we,
    input  logic          cmpc_we,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cmpa,
    output logic [CW-1:0] cmpc,
    output ch_mode_t      mode,
    output logic          running,
    output logic          wave,
    output logic          evt
);
    logic [CW-1:0] nxt;

    always_comb begin
        if (mode.auto_rld && cnt == cmpc) nxt = '0;
        else                              nxt = cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cmpa    <= '0;
            cmpc    <= '0;
            mode    <= '0;
            running <= 1'b0;
            wave    <= 1'b0;
            evt     <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (mode_we) mode <= ch_mode_t'(wdata[3:0]);
            if (cmpa_we) cmpa <= wdata[CW-1:0];
            if (cmpc_we) cmpc <= wdata[CW-1:0];
            if (trig) begin
                cnt <= '0;
            end else if (running && tick) begin
                cnt <= nxt;
                if (nxt == cmpc) begin
                    wave <= 1'b0;
                    evt  <= 1'b1;
                    if (mode.stop_on_c) running <= 1'b0;
                end else if (nxt == cmpa) begin
                    wave <= 1'b1;
                end
            end
            if (cmd_we) begin
                if (wdata[1])      running <= 1'b0;
                else if (wdata[0]) running <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_block3.sv
module tmr_block3
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          slow_clk,
    output logic [NCH-1:0] wave_out,
    output logic [NCH-1:0] cmp_evt
);
    logic [SELW-1:0] sel;
    logic [OFSW-1:0] ofs;
    logic            sync_we;
    logic            slow_rise;
    logic [RTW-1:0]  route_q;
    logic [CW-1:0]   hold_q;
    logic [NCH-1:0]  trig;
    logic [NCH-1:0]  running;
    logic [CW-1:0]   cnt  [NCH];
    logic [CW-1:0]   cmpa [NCH];
    logic [CW-1:0]   cmpc [NCH];
    ch_mode_t        mode [NCH];

    assign sel     = bus_addr[AW-1:OFSW];
    assign ofs     = bus_addr[OFSW-1:0];
    assign sync_we = bus_wr && bus_addr == BLK_CMD && bus_wdata[0];

    tmr_rise u_slow (.clk(clk), .rst(rst), .din(slow_clk), .rise(slow_rise));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic rt_src, rt_rise, tick, hit;

        always_comb begin
            case (route_e'(route_q[2*n +: 2]))
                RT_PREV: rt_src = wave_out[prev_ch(n)];
                RT_NEXT: rt_src = wave_out[next_ch(n)];
                default: rt_src = 1'b0;
            endcase
        end

        tmr_rise u_rt (.clk(clk), .rst(rst), .din(rt_src), .rise(rt_rise));

        always_comb begin
            case (mode[n].src)
                SRC_MCK:  tick = 1'b1;
                SRC_SLOW: tick = slow_rise;
                SRC_RTE:  tick = rt_rise;
                default:  tick = 1'b0;
            endcase
        end

        assign hit     = bus_wr && sel == SELW'(n);
        assign trig[n] = (hit && ofs == OFS_CMD && bus_wdata[2]) || sync_we;

        tmr_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .trig    (trig[n]),
            .cmd_we  (hit && ofs == OFS_CMD),
            .mode_we (hit && ofs == OFS_MODE),
            .cmpa_we (hit && ofs == OFS_CMPA),
            .cmpc_we (hit && ofs == OFS_CMPC),
            .wdata   (bus_wdata),
            .cnt     (cnt[n]),
            .cmpa    (cmpa[n]),
            .cmpc    (cmpc[n]),
            .mode    (mode[n]),
            .running (running[n]),
            .wave    (wave_out[n]),
            .evt     (cmp_evt[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            hold_q  <= '0;
        end else begin
            if (bus_wr && bus_addr == BLK_ROUTE) route_q <= bus_wdata[RTW-1:0];
            if (bus_rd && bus_addr == VIEW_LO)   hold_q  <= cnt[1];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (sel == SELW'(n)) begin
                case (ofs)
                    OFS_MODE: bus_rdata = DW'(mode[n]);
                    OFS_CMPA: bus_rdata = DW'(cmpa[n]);
                    OFS_CMPC: bus_rdata = DW'(cmpc[n]);
                    OFS_CNT:  bus_rdata = DW'(cnt[n]);
                    default:  bus_rdata = '0;
                endcase
            end
        end
        case (bus_addr)
            BLK_ROUTE: bus_rdata = DW'(route_q);
            VIEW_LO:   bus_rdata = DW'(cnt[0]);
            VIEW_HI:   bus_rdata = DW'(hold_q);
            default:   ;
        endcase
    end
endmodule

// File: rtl/tmr_block3_chk.sv
module tmr_block3_chk
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [CW-1:0]  c0,
    input logic [CW-1:0]  c1,
    input logic [CW-1:0]  c2,
    input logic [CW-1:0]  hold,
    input logic [RTW-1:0] route,
    input logic [NCH-1:0] trig,
    input logic [NCH-1:0] evt,
    input logic           stop2
);
    p_sync_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == BLK_CMD && bus_wdata[0]) |=> (c0 == '0 && c1 == '0 && c2 == '0));

    p_view_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == VIEW_LO) |=> hold == $past(c1));

    p_route_back_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == BLK_ROUTE) |=> route == $past(bus_wdata[RTW-1:0]));

    p_one_step_r8: assert property (@(posedge clk) disable iff (rst)
        (c1 != $past(c1)) |-> (c1 == $past(c1) + CW'(1) || c1 == '0));

    p_oneshot_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (evt[2] && stop2 && !trig[2]) |=> $stable(c2));
endmodule

bind tmr_block3 tmr_block3_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .c0        (cnt[0]),
    .c1        (cnt[1]),
    .c2        (cnt[2]),
    .hold      (hold_q),
    .route     (route_q),
    .trig      (trig),
    .evt       (cmp_evt),
    .stop2     (mode[2].stop_on_c)
);

// File: tb/tmr_block3_tb.sv
`timescale 1ns/1ps
module tmr_block3_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        slow_clk = 1'b0;
    logic [31:0] rdata, rdata32;
    logic [2:0]  wave, evt, wave32, evt32;
    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        int          bitn;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    tmr_block3 #(.CW(16)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .slow_clk(slow_clk),
        .wave_out(wave), .cmp_evt(evt));

    tmr_block3 #(.CW(32)) u_dut32 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata32), .slow_clk(slow_clk),
        .wave_out(wave32), .cmp_evt(evt32));

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = rdata;
                1: act = 32'(wave[it.bitn]);
                2: act = 32'(evt[it.bitn]);
                default: act = rdata32;
            endcase
            vectors++;
            if (act !== it.exp) begin
                miscompares++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic expect_out(input int kind, input int bitn, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.bitn = bitn; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        expect_out(0, 0, e, tag);
        step();
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        expect_out(1, 0, 0, "R1 wave0"); expect_out(1, 2, 0, "R1 wave2");
        expect_out(2, 2, 0, "R1 evt2");
        rd(8'h10, 0, "R1 cnt0");
        rd(8'h50, 0, "R1 cnt1");
        rd(8'h90, 0, "R1 cnt2");
        rd(8'hC4, 0, "R1 route");

        // R2 master clock, start/stop/trigger
        wr(8'h00, 32'h5);
        repeat (9) step();
        rd(8'h10, 9, "R2 count");
        wr(8'h00, 32'h2);
        repeat (5) step();
        rd(8'h10, 11, "R2 hold when stopped");
        wr(8'h00, 32'h3);
        repeat (3) step();
        rd(8'h10, 11, "R2 stop wins");

        // R4/R5 channel 2 periodic, A=2, C=5
        wr(8'h84, 32'h4);
        wr(8'h88, 32'd2);
        wr(8'h8C, 32'd5);
        wr(8'h80, 32'h5);
        for (int k = 0; k < 13; k++) begin
            int c;
            c = k % 6;
            expect_out(1, 2, 32'((c >= 2) && (c <= 4)), "R4 wave2");
            expect_out(2, 2, 32'(c == 5), "R5 evt2");
            rd(8'h90, 32'(c), "R5 reload count");
        end
        wr(8'h80, 32'h2);

        // R6 one-shot, C=4
        wr(8'h84, 32'hC);
        wr(8'h8C, 32'd4);
        wr(8'h80, 32'h5);
        for (int k = 0; k < 8; k++) begin
            expect_out(2, 2, 32'(k == 4), "R6 evt once");
            rd(8'h90, (k < 4) ? 32'(k) : 32'd4, "R6 stop at C");
        end
        wr(8'h80, 32'h5);
        rd(8'h90, 0, "R6 restart");
        rd(8'h90, 1, "R6 restart count");

        // R11 slow clock source
        wr(8'h84, 32'h1);
        wr(8'h80, 32'h5);
        slow_clk = 1'b1;
        repeat (4) step();
        rd(8'h90, 1, "R11 level held");
        slow_clk = 1'b0; step();
        slow_clk = 1'b1; step();
        slow_clk = 1'b0; step();
        slow_clk = 1'b1; step();
        slow_clk = 1'b0; step();
        rd(8'h90, 3, "R11 edges");

        // R7 routing register
        wr(8'hC4, 32'h2D);
        rd(8'hC4, 32'h2D, "R7 readback");
        wr(8'hC4, 32'hFFFF);
        rd(8'hC4, 32'h3F, "R7 mask");

        // R8/R9/R10/R12/R3 chaining
        wr(8'h44, 32'h2);
        wr(8'hC4, 32'h04);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h8000);
        wr(8'h40, 32'h1);
        wr(8'h00, 32'h1);
        wr(8'hC0, 32'h1);
        expect_out(3, 0, 0, "R10 cnt2 zero wide");
        rd(8'h90, 0, "R10 cnt2 zero");
        repeat (65534) step();
        expect_out(1, 0, 0, "R4 wave0 low");
        expect_out(3, 0, 32'hFFFF, "R3 wide low view");
        rd(8'hC8, 32'hFFFF, "R12 view low");
        expect_out(1, 0, 1, "R4 wave0 set at A");
        expect_out(3, 0, 32'h10000, "R3 wide past 16 bits");
        rd(8'h10, 0, "R3 wrap");
        rd(8'hCC, 0, "R12 held high");
        rd(8'h50, 1, "R9 upper half");
        rd(8'hC8, 3, "R8 low after wrap");
        rd(8'hCC, 1, "R12 held high updated");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule